// File: doc/BRIEF.md
# Credit-Ordered Data and Control Channel

This block carries two streams from one producer to one consumer. Data items and control signals travel in separate FIFOs, and the signal FIFO is usually much shallower than the data FIFO. Each signal is stored with a credit count. The credit is the number of data items that must leave the block before that signal may leave. No tag is added to any data item.

The producer offers items and signals on two valid/ready push ports. On a signal push the block computes the credit as follows:
- If no signal is waiting, the credit is the number of items that will be held after this cycle.
- If a signal is waiting, the credit is the number of items pushed since the previous signal push.

The consumer side has a current-credit register. It uses that register and the head signal's credit to choose what the single pop port shows: a data item or a signal. The pop port marks each entry as data or signal. Taken together, the consumer sees one interleaved stream, identical to the order in which the producer pushed items and signals.

Top module: `credit_sync_channel`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), out_valid is 0 and both push ports are ready.
- R2: While no signal is held, data items leave in push order whenever out_ready is high. The credit register plays no part.
- R3: Every signal leaves after every data item pushed before it, and before every data item pushed after it. Signals leave in the order they were pushed.
- R4: A signal pushed while the signal FIFO is empty is held back until every item then in the data FIFO has left.
- R5: When a data push and a signal push happen in the same cycle, the data item goes ahead of the signal in the output order.
- R6: A signal with zero credit is presented at once. Signals pushed back to back, with no data between them, leave in consecutive pops.
- R7: d_in_ready is low when the data FIFO holds DDEPTH items. It is also low when 2**CRED_W-1 items have been pushed since the last signal push. s_in_ready is low when the signal FIFO holds SDEPTH signals.
- R8: While out_valid is high and out_ready is low, the presented entry holds steady. This covers out_valid, out_is_sig (1 = signal, 0 = data) and the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| d_in_valid | input | 1 | Producer offers a data item |
| d_in_data | input | DATA_W | Data item payload |
| d_in_ready | output | 1 | Data item accepted this cycle if valid |
| s_in_valid | input | 1 | Producer offers a signal |
| s_in_data | input | SIG_W | Signal payload |
| s_in_ready | output | 1 | Signal accepted this cycle if valid |
| out_valid | output | 1 | An entry is presented to the consumer |
| out_is_sig | output | 1 | 1: presented entry is a signal; 0: data item |
| out_data | output | DATA_W | Data payload, meaningful when out_is_sig is 0 |
| out_sig | output | SIG_W | Signal payload, meaningful when out_is_sig is 1 |
| out_ready | input | 1 | Consumer takes the presented entry |

## Verification
The bench targets three cases:
- Items held in the data FIFO when a signal arrives at an empty signal FIFO. A design that used the run counter here would release the signal too early.
- Data and signal pushed in the same cycle. A design that left the item out of the credit would let the signal overtake it.
- Runs of zero-credit signals. A design that needed a credit transfer step would stall, or would show a stale entry.

Long stretches with out_ready low fill both FIFOs and reach the run limit. A wrong stall rule would then drop entries, or accept entries that overwrite ones still held. Random back-pressure checks that the presented entry never changes until it is taken.

// File: rtl/credit_sync_channel.sv
module credit_sync_channel #(
  parameter int DATA_W = 16,
  parameter int SIG_W  = 8,
  parameter int DDEPTH = 8,
  parameter int SDEPTH = 4,
  parameter int CRED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_in_valid,
  input  logic [DATA_W-1:0] d_in_data,
  output logic              d_in_ready,
  input  logic              s_in_valid,
  input  logic [SIG_W-1:0]  s_in_data,
  output logic              s_in_ready,
  output logic              out_valid,
  output logic              out_is_sig,
  output logic [DATA_W-1:0] out_data,
  output logic [SIG_W-1:0]  out_sig,
  input  logic              out_ready
);
  localparam int DAW = (DDEPTH > 1) ? $clog2(DDEPTH) : 1;
  localparam int SAW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1;
  localparam logic [DAW:0]      D_FULL  = (DAW+1)'(DDEPTH);
  localparam logic [SAW:0]      S_FULL  = (SAW+1)'(SDEPTH);
  localparam logic [DAW-1:0]    D_LAST  = DAW'(DDEPTH - 1);
  localparam logic [SAW-1:0]    S_LAST  = SAW'(SDEPTH - 1);
  localparam logic [CRED_W-1:0] RUN_MAX = '1;

  logic [DATA_W-1:0] dmem  [DDEPTH];
  logic [SIG_W-1:0]  spay  [SDEPTH];
  logic [CRED_W-1:0] scred [SDEPTH];
  logic [DAW-1:0]    dwr, drd;
  logic [SAW-1:0]    swr, srd;
  logic [DAW:0]      dcnt;
  logic [SAW:0]      scnt;
  logic [CRED_W-1:0] run_cnt, credit;
  logic              head_used;

  wire               sig_q    = (scnt != '0);
  wire [CRED_W-1:0]  head_c   = head_used ? '0 : scred[srd];
  wire [CRED_W-1:0]  eff      = (credit != '0) ? credit : head_c;
  wire               show_sig = sig_q && (eff == '0);

  assign out_valid  = show_sig || (dcnt != '0);
  assign out_is_sig = show_sig;
  assign out_data   = dmem[drd];
  assign out_sig    = spay[srd];
  assign d_in_ready = (dcnt != D_FULL) && (run_cnt != RUN_MAX);
  assign s_in_ready = (scnt != S_FULL);

  wire dpush = d_in_valid && d_in_ready;
  wire spush = s_in_valid && s_in_ready;
  wire dpop  = out_valid && out_ready && !show_sig;
  wire spop  = out_valid && out_ready && show_sig;

  wire [CRED_W-1:0] new_cred = sig_q
      ? run_cnt + CRED_W'(dpush)
      : CRED_W'(dcnt) - CRED_W'(dpop) + CRED_W'(dpush);

  always_ff @(posedge clk) begin
    if (dpush) dmem[dwr] <= d_in_data;
    if (spush) begin
      spay[swr]  <= s_in_data;
      scred[swr] <= new_cred;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dwr <= '0; drd <= '0; dcnt <= '0;
      swr <= '0; srd <= '0; scnt <= '0;
      run_cnt <= '0; credit <= '0; head_used <= 1'b0;
    end else begin
      if (dpush) dwr <= (dwr == D_LAST) ? '0 : dwr + 1'b1;
      if (dpop)  drd <= (drd == D_LAST) ? '0 : drd + 1'b1;
      dcnt <= dcnt + (DAW+1)'(dpush) - (DAW+1)'(dpop);
      if (spush) swr <= (swr == S_LAST) ? '0 : swr + 1'b1;
      if (spop)  srd <= (srd == S_LAST) ? '0 : srd + 1'b1;
      scnt <= scnt + (SAW+1)'(spush) - (SAW+1)'(spop);
      run_cnt <= spush ? '0 : run_cnt + CRED_W'(dpush);
      if (dpop && sig_q) begin
        credit <= eff - 1'b1;
        if (credit == '0) head_used <= 1'b1;
      end
      if (spop) head_used <= 1'b0;
    end
  end
endmodule

module credit_sync_channel_chk #(
  parameter int DATA_W = 16,
  parameter int SIG_W  = 8,
  parameter int DDEPTH = 8,
  parameter int SDEPTH = 4,
  parameter int CRED_W = 4,
  parameter int DAW    = 3,
  parameter int SAW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_sig,
  input logic [DATA_W-1:0] out_data,
  input logic [SIG_W-1:0]  out_sig,
  input logic [DAW:0]      dcnt,
  input logic [SAW:0]      scnt,
  input logic [CRED_W-1:0] credit
);
  always @(negedge clk)
    if (!rst_n) p_reset_idle_r1: assert (!out_valid);

  p_idle_credit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scnt == '0 |-> credit == '0);

  p_credit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scnt != '0 |-> int'(credit) <= int'(dcnt));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dcnt) <= DDEPTH && int'(scnt) <= SDEPTH);

  p_hold_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_is_sig));

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !out_is_sig |=> out_data == $past(out_data));

  p_hold_sig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && out_is_sig |=> out_sig == $past(out_sig));
endmodule

bind credit_sync_channel credit_sync_channel_chk #(
  .DATA_W(DATA_W), .SIG_W(SIG_W), .DDEPTH(DDEPTH), .SDEPTH(SDEPTH),
  .CRED_W(CRED_W), .DAW(DAW), .SAW(SAW)
) u_chk (.*);

// File: tb/credit_sync_channel_bench.sv
module credit_sync_channel_bench;
  localparam int DATA_W = 16, SIG_W = 8, DDEPTH = 8, SDEPTH = 4, CRED_W = 4;
  localparam int RUN_MAX = (1 << CRED_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, d_in_valid, d_in_ready, s_in_valid, s_in_ready;
  logic out_valid, out_is_sig, out_ready;
  logic [DATA_W-1:0] d_in_data, out_data;
  logic [SIG_W-1:0]  s_in_data, out_sig;

  credit_sync_channel #(.DATA_W(DATA_W), .SIG_W(SIG_W), .DDEPTH(DDEPTH),
    .SDEPTH(SDEPTH), .CRED_W(CRED_W)) u_credit_sync_channel (.*);

  typedef struct { bit is_sig; int val; } ent_t;
  ent_t  exp_q[$];
  int    checks = 0, fails = 0, d_held = 0, s_held = 0, run = 0;
  int    dseq = 1, sseq = 1;
  string tag = "R1";

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic step(bit dv, bit sv, bit ordy);
    @(negedge clk);
    d_in_valid = dv; d_in_data = DATA_W'(dseq);
    s_in_valid = sv; s_in_data = SIG_W'(sseq);
    out_ready  = ordy;
    #4;
    chk(out_valid == (exp_q.size() != 0), "out_valid", int'(out_valid), int'(exp_q.size() != 0));
    if (out_valid && exp_q.size() != 0) begin
      chk(out_is_sig == exp_q[0].is_sig, "out_is_sig", int'(out_is_sig), int'(exp_q[0].is_sig));
      if (exp_q[0].is_sig)
        chk(int'(out_sig) == (exp_q[0].val & 8'hFF), "out_sig", int'(out_sig), exp_q[0].val & 8'hFF);
      else
        chk(int'(out_data) == (exp_q[0].val & 16'hFFFF), "out_data", int'(out_data), exp_q[0].val & 16'hFFFF);
    end
    if (rst_n) begin
      chk(d_in_ready == (d_held < DDEPTH && run < RUN_MAX), "d_in_ready (R7)",
          int'(d_in_ready), int'(d_held < DDEPTH && run < RUN_MAX));
      chk(s_in_ready == (s_held < SDEPTH), "s_in_ready (R7)",
          int'(s_in_ready), int'(s_held < SDEPTH));
    end
    if (rst_n && out_valid && out_ready && exp_q.size() != 0) begin
      if (exp_q[0].is_sig) s_held--; else d_held--;
      void'(exp_q.pop_front());
    end
    if (rst_n && dv && d_in_ready) begin
      exp_q.push_back('{1'b0, dseq}); d_held++; run++; dseq++;
    end
    if (rst_n && sv && s_in_ready) begin
      exp_q.push_back('{1'b1, sseq}); s_held++; run = 0; sseq++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) step(0, 0, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R3 watchdog expired: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; d_in_valid = 0; s_in_valid = 0; out_ready = 0;
    d_in_data = '0; s_in_data = '0;
    step(0, 0, 0); step(0, 0, 0);
    rst_n = 1'b1;
    tag = "R1";
    step(0, 0, 0);
    chk(d_in_ready && s_in_ready, "readies after reset", int'(d_in_ready && s_in_ready), 1);

    tag = "R2";
    for (int i = 0; i < 6; i++) step(1, 0, i % 2);
    drain();

    tag = "R4";
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    step(0, 1, 0);
    step(1, 0, 0); step(1, 0, 0);
    step(0, 1, 0);
    drain();

    tag = "R5";
    step(1, 1, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    drain();

    tag = "R6";
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    step(1, 0, 0); step(0, 1, 0); step(0, 1, 0);
    drain();

    tag = "R7";
    for (int i = 0; i < 11; i++) step(1, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 1, 0);
    drain();
    for (int j = 0; j < 3; j++) begin
      for (int i = 0; i < 6; i++) step(1, 0, 1);
      step(0, 0, 1);
    end
    for (int i = 0; i < 18; i++) step(1, 0, i % 3 == 0);
    step(0, 1, 1);
    drain();

    tag = "R3/R8";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 2, $urandom_range(0, 9) < 5);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule